// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer with Cascade Bus

This block answers the processor's interrupt acknowledge pulses and places the response bytes on the data bus. It takes the winning interrupt level from a separate priority core. On the first falling acknowledge edge it latches that level and raises a one-cycle in-service strobe. It then answers with one of two sequences. The call-style sequence has three pulses: an opcode byte, then the low and high bytes of a handler address. The vector-style sequence has two pulses: the first returns nothing and only freezes the level, and the second returns a vector byte built from a programmed base and the level number.

Several controllers can share one processor over a 3-bit private cascade bus. There is one master and up to eight slaves, for 64 levels in total. A master whose winning level has a slave attached drives that level number on the cascade lines, and the addressed slave supplies the address or vector bytes. A slave compares the cascade code with its own identity and drives the data bus only on a match. Outside buffered mode, a strap input selects master or slave. In buffered mode the same pin becomes an active-low output that enables an external transceiver while the block drives the data bus. The acknowledge path has no chip-select input. The acknowledge input is taken to be synchronous to the clock.

Top module: `intack_seq`

## Requirements
- R1: After reset, data_oe, cas_oe, isr_set and pulse counting are all zero. cas_out is 0.
- R2: On the clock edge that samples the first falling acknowledge edge of a sequence, the block latches the level. That level is win_level when win_valid is high and 7 when it is low. isr_set goes high for exactly one cycle, with isr_lvl holding the latched level.
- R3: In three-pulse mode (call_mode=1) a responsible master returns 8'hCD on pulse 1. On pulse 2 it returns the low byte {call_lo[2:0], level, 2'b00} and on pulse 3 the high byte call_hi.
- R4: In two-pulse mode (call_mode=0) nothing is driven on pulse 1. On pulse 2 the vector {vec_base[4:0], level} is driven.
- R5: data_oe rises on the edge that first samples the acknowledge input low on a driven pulse. It falls on the edge that first samples it high again.
- R6: A master whose latched level has its slave_map bit set drives cas_out = level with cas_oe=1. This runs from the edge of the first falling acknowledge edge to the edge after the last pulse rises. Such a master drives only the opcode pulse in three-pulse mode, and nothing in two-pulse mode.
- R7: A master whose latched level has no slave_map bit keeps cas_oe at 0 and cas_out at 0.
- R8: A slave samples cas_in at the second falling acknowledge edge. It drives the data bus on the address or vector pulses only when that code equals slave_id. It never drives pulse 1.
- R9: The role is latched at the first falling edge. Outside buffered mode (buf_mode=0) sp_en_in=1 means master and sp_en_in=0 means slave, and sp_en_oe=0. In buffered mode the role comes from cfg_master, sp_en_oe=1, and sp_en_out is the inverse of data_oe.
- R10: A sequence ends after the rising edge of its last pulse (pulse 3 in three-pulse mode, pulse 2 in two-pulse mode). The next falling edge starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inta_n | input | 1 | Acknowledge pulse from processor, active low |
| call_mode | input | 1 | 1 = three-pulse sequence, 0 = two-pulse |
| buf_mode | input | 1 | Buffered mode: strap pin becomes enable output |
| cfg_master | input | 1 | Role used in buffered mode (1 = master) |
| sp_en_in | input | 1 | Strap input, 1 = master, outside buffered mode |
| sp_en_out | output | 1 | Active-low transceiver enable in buffered mode |
| sp_en_oe | output | 1 | Drive enable for the strap/enable pin |
| win_valid | input | 1 | Priority core has a winning level |
| win_level | input | 3 | Winning level |
| slave_map | input | 8 | Levels that have a slave attached (master) |
| slave_id | input | 3 | Own identity (slave) |
| vec_base | input | 5 | Upper vector bits |
| call_lo | input | 3 | Upper bits of the low address byte |
| call_hi | input | 8 | High address byte |
| cas_in | input | 3 | Cascade code sampled by a slave |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_oe | output | 1 | Cascade drive enable |
| data_out | output | 8 | Response byte |
| data_oe | output | 1 | Data bus drive enable |
| isr_set | output | 1 | One-cycle in-service strobe |
| isr_lvl | output | 3 | Level being acknowledged |

## Verification
A master without cascading is run through both sequence lengths at several levels, which checks the byte order and the level insertion. A cascaded master is tried at one level with a slave and one without, which shows whether the cascade code appears and whether byte ownership passes to the slave. A slave is given a matching code and a mismatching code, and a run with no valid winner checks the fallback level. Buffered mode is checked with the role coming from configuration rather than from the strap pin. Back-to-back sequences check that pulse counting restarts.

// File: rtl/intack_pkg.sv
// Shared constants and types for the acknowledge sequencer.
// Assumes an 8-bit data bus and a 3-bit level code.
package intack_pkg;
    localparam logic [7:0] CALL_OPCODE = 8'hCD;
    typedef logic [1:0] pulse_idx_t;
endpackage

// File: rtl/intack_pulse_track.sv
// Tracks acknowledge edges and counts the pulses of one sequence.
// Assumes inta_n is already synchronous to clk.
module intack_pulse_track
    import intack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inta_n,
    input  logic       call_mode,
    output logic       ack_q,
    output logic       fall,
    output logic       rise,
    output pulse_idx_t idx,
    output logic       mode_q,
    output logic       seq_end
);
    pulse_idx_t cnt;

    assign fall    = ack_q & ~inta_n;
    assign rise    = ~ack_q & inta_n;
    assign idx     = cnt;
    assign seq_end = rise && (cnt == (mode_q ? 2'd3 : 2'd2));

    // Register the input, count the falling edges and latch the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b1;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            ack_q <= inta_n;
            if (fall) begin
                cnt <= cnt + 2'd1;
                if (cnt == 2'd0) mode_q <= call_mode;
            end else if (seq_end) begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/intack_cascade.sv
// Latches level and role at the first edge and drives the cascade code
// as master or matches it as slave. Assumes slaves sit on levels set in map.
module intack_cascade #(
    parameter int LVL_W = 3,
    localparam int NLVL = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic             second,
    input  logic             seq_end,
    input  logic             role_live,
    input  logic [LVL_W-1:0] lvl_live,
    input  logic [NLVL-1:0]  slave_map,
    input  logic [LVL_W-1:0] slave_id,
    input  logic [LVL_W-1:0] cas_in,
    output logic [LVL_W-1:0] level_q,
    output logic             role_q,
    output logic             casc_q,
    output logic             hit_live,
    output logic             hit_q,
    output logic [LVL_W-1:0] cas_out,
    output logic             cas_oe
);
    assign hit_live = (cas_in == slave_id);

    // Capture sequence context and run the cascade drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            role_q  <= 1'b0;
            casc_q  <= 1'b0;
            hit_q   <= 1'b0;
            cas_out <= '0;
            cas_oe  <= 1'b0;
        end else begin
            if (first) begin
                level_q <= lvl_live;
                role_q  <= role_live;
                casc_q  <= role_live && slave_map[lvl_live];
                hit_q   <= 1'b0;
                cas_oe  <= role_live && slave_map[lvl_live];
                cas_out <= (role_live && slave_map[lvl_live]) ? lvl_live : '0;
            end else if (seq_end) begin
                cas_oe  <= 1'b0;
                cas_out <= '0;
            end
            if (second) hit_q <= hit_live;
        end
    end

    // R6: the cascade code holds steady while it is driven
    p_cas_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_oe && $past(cas_oe)) |-> $stable(cas_out));
    // R9: only a master starts driving the cascade lines
    p_cas_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_oe) |-> role_q);
endmodule

// File: rtl/intack_byte_sel.sv
// Chooses whether this controller owns the current pulse and which byte it returns.
// Pure combinational; assumes DW > LVL_W + 2.
module intack_byte_sel
    import intack_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int DW    = 8,
    localparam int VB_W = DW - LVL_W,
    localparam int LO_W = DW - LVL_W - 2
) (
    input  logic             is_master,
    input  logic             three_pulse,
    input  pulse_idx_t       idx,
    input  logic             cascaded,
    input  logic             slave_hit,
    input  logic [LVL_W-1:0] level,
    input  logic [VB_W-1:0]  vec_base,
    input  logic [LO_W-1:0]  call_lo,
    input  logic [DW-1:0]    call_hi,
    output logic             drive,
    output logic [DW-1:0]    byte_val
);
    logic addr_pulse;
    assign addr_pulse = (idx == 2'd1) || (idx == 2'd2);

    // Decide ownership of the pulse
    always_comb begin
        if (is_master)
            drive = three_pulse ? ((idx == 2'd0) || (addr_pulse && !cascaded))
                                : ((idx == 2'd1) && !cascaded);
        else
            drive = three_pulse ? (addr_pulse && slave_hit)
                                : ((idx == 2'd1) && slave_hit);
    end

    // Select the response byte
    always_comb begin
        if (!three_pulse)       byte_val = {vec_base, level};
        else if (idx == 2'd0)   byte_val = CALL_OPCODE;
        else if (idx == 2'd1)   byte_val = {call_lo, level, 2'b00};
        else                    byte_val = call_hi;
    end
endmodule

// File: rtl/intack_seq.sv
// Top of the acknowledge sequencer: pulse tracking, cascade handling and
// data bus drive. Assumes synchronous acknowledge input and stable config.
module intack_seq
    import intack_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int DW    = 8,
    localparam int NLVL = 1 << LVL_W,
    localparam int VB_W = DW - LVL_W,
    localparam int LO_W = DW - LVL_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inta_n,
    input  logic             call_mode,
    input  logic             buf_mode,
    input  logic             cfg_master,
    input  logic             sp_en_in,
    output logic             sp_en_out,
    output logic             sp_en_oe,
    input  logic             win_valid,
    input  logic [LVL_W-1:0] win_level,
    input  logic [NLVL-1:0]  slave_map,
    input  logic [LVL_W-1:0] slave_id,
    input  logic [VB_W-1:0]  vec_base,
    input  logic [LO_W-1:0]  call_lo,
    input  logic [DW-1:0]    call_hi,
    input  logic [LVL_W-1:0] cas_in,
    output logic [LVL_W-1:0] cas_out,
    output logic             cas_oe,
    output logic [DW-1:0]    data_out,
    output logic             data_oe,
    output logic             isr_set,
    output logic [LVL_W-1:0] isr_lvl
);
    logic ack_q, fall, rise, mode_q, seq_end, first, second;
    pulse_idx_t idx;
    logic role_live, role_q, casc_q, hit_live, hit_q, hit_eff, role_eff, mode_eff;
    logic [LVL_W-1:0] lvl_live, level_q;
    logic drive;
    logic [DW-1:0] byte_val;

    assign role_live = buf_mode ? cfg_master : sp_en_in;
    assign lvl_live  = win_valid ? win_level : LVL_W'(NLVL - 1);
    assign first     = fall && (idx == 2'd0);
    assign second    = fall && (idx == 2'd1);
    assign role_eff  = first ? role_live : role_q;
    assign mode_eff  = first ? call_mode : mode_q;
    assign hit_eff   = second ? hit_live : hit_q;
    assign sp_en_oe  = buf_mode;
    assign sp_en_out = ~data_oe;

    intack_pulse_track u_track (
        .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .call_mode(call_mode),
        .ack_q(ack_q), .fall(fall), .rise(rise), .idx(idx),
        .mode_q(mode_q), .seq_end(seq_end)
    );

    intack_cascade #(.LVL_W(LVL_W)) u_casc (
        .clk(clk), .rst_n(rst_n), .first(first), .second(second),
        .seq_end(seq_end), .role_live(role_live), .lvl_live(lvl_live),
        .slave_map(slave_map), .slave_id(slave_id), .cas_in(cas_in),
        .level_q(level_q), .role_q(role_q), .casc_q(casc_q),
        .hit_live(hit_live), .hit_q(hit_q), .cas_out(cas_out), .cas_oe(cas_oe)
    );

    intack_byte_sel #(.LVL_W(LVL_W), .DW(DW)) u_sel (
        .is_master(role_eff), .three_pulse(mode_eff), .idx(idx),
        .cascaded(casc_q), .slave_hit(hit_eff), .level(level_q),
        .vec_base(vec_base), .call_lo(call_lo), .call_hi(call_hi),
        .drive(drive), .byte_val(byte_val)
    );

    // Drive the data bus per pulse and raise the in-service strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_oe  <= 1'b0;
            data_out <= '0;
            isr_set  <= 1'b0;
            isr_lvl  <= '0;
        end else begin
            isr_set <= first;
            if (first) isr_lvl <= lvl_live;
            if (fall) begin
                data_oe  <= drive;
                data_out <= byte_val;
            end else if (rise) begin
                data_oe  <= 1'b0;
            end
        end
    end

    // R5: the bus is driven only while the pulse is low
    p_oe_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !ack_q);
    // R2: the in-service strobe lasts one cycle
    p_isr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        isr_set |=> !isr_set);
    // R4: in two-pulse mode only the second pulse carries data
    p_vec_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && !mode_q) |-> (idx == 2'd2));
    // R8: a slave drives only after a cascade match
    p_slave_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && !role_q) |-> hit_q);
endmodule

// File: tb/intack_seq_bench.sv
module intack_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inta_n = 1'b1, call_mode = 1'b0, buf_mode = 1'b0, cfg_master = 1'b0;
    logic sp_en_in = 1'b1, win_valid = 1'b0;
    logic [2:0] win_level = 3'd0, slave_id = 3'd0, cas_in = 3'd0, call_lo = 3'd0;
    logic [7:0] slave_map = 8'd0, call_hi = 8'd0;
    logic [4:0] vec_base = 5'd0;
    logic sp_en_out, sp_en_oe, cas_oe, data_oe, isr_set;
    logic [2:0] cas_out, isr_lvl;
    logic [7:0] data_out;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    intack_seq u_intack_seq (
        .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .call_mode(call_mode),
        .buf_mode(buf_mode), .cfg_master(cfg_master), .sp_en_in(sp_en_in),
        .sp_en_out(sp_en_out), .sp_en_oe(sp_en_oe), .win_valid(win_valid),
        .win_level(win_level), .slave_map(slave_map), .slave_id(slave_id),
        .vec_base(vec_base), .call_lo(call_lo), .call_hi(call_hi),
        .cas_in(cas_in), .cas_out(cas_out), .cas_oe(cas_oe),
        .data_out(data_out), .data_oe(data_oe), .isr_set(isr_set), .isr_lvl(isr_lvl)
    );

    // Behavioural reference model
    bit m_prev = 1, m_mode, m_master, m_casc, m_sel, in_reset = 1;
    int m_cnt = 0, m_lvl = 0;
    bit e_doe, e_isr, e_cas_oe;
    int e_dout, e_cas, e_isr_lvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1; m_cnt = 0; e_doe = 0; e_isr = 0; e_cas_oe = 0; e_cas = 0;
            e_dout = 0; m_sel = 0;
        end else begin
            e_isr = 0;
            if (m_prev && !inta_n) begin
                if (m_cnt == 0) begin
                    m_lvl = win_valid ? int'(win_level) : 7;
                    m_mode = call_mode;
                    m_master = buf_mode ? cfg_master : sp_en_in;
                    m_casc = m_master && slave_map[m_lvl];
                    e_isr = 1; e_isr_lvl = m_lvl;
                    e_cas_oe = m_casc; e_cas = m_casc ? m_lvl : 0;
                end
                if (m_cnt == 1) m_sel = (cas_in == slave_id);
                if (m_master)
                    e_doe = m_mode ? (m_cnt == 0 || ((m_cnt == 1 || m_cnt == 2) && !m_casc))
                                   : (m_cnt == 1 && !m_casc);
                else
                    e_doe = m_mode ? ((m_cnt == 1 || m_cnt == 2) && m_sel)
                                   : (m_cnt == 1 && m_sel);
                if (!m_mode) e_dout = vec_base * 8 + m_lvl;
                else if (m_cnt == 0) e_dout = 'hCD;
                else if (m_cnt == 1) e_dout = call_lo * 32 + m_lvl * 4;
                else e_dout = call_hi;
                m_cnt++;
            end else if (!m_prev && inta_n) begin
                e_doe = 0;
                if (m_cnt == (m_mode ? 3 : 2)) begin   // R10: sequence end
                    m_cnt = 0; e_cas_oe = 0; e_cas = 0;
                end
            end
            m_prev = inta_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n && !in_reset) begin
            chk(data_oe == e_doe, m_master ? "R5 data_oe" : "R8 data_oe", data_oe, e_doe);
            if (e_doe)
                chk(data_out == e_dout[7:0], m_mode ? "R3 data_out" : "R4 data_out",
                    data_out, e_dout);
            chk(cas_oe == e_cas_oe, m_casc ? "R6 cas_oe" : "R7 cas_oe", cas_oe, e_cas_oe);
            chk(cas_out == e_cas[2:0], m_casc ? "R6 cas_out" : "R7 cas_out", cas_out, e_cas);
            chk(isr_set == e_isr, "R2 isr_set", isr_set, e_isr);
            if (e_isr) chk(isr_lvl == e_isr_lvl[2:0], "R2 isr_lvl", isr_lvl, e_isr_lvl);
            chk(sp_en_oe == buf_mode, "R9 sp_en_oe", sp_en_oe, buf_mode);
            if (buf_mode) chk(sp_en_out == !e_doe, "R9 sp_en_out", sp_en_out, !e_doe);
        end
    end

    task automatic pulse();
        @(posedge clk); #1 inta_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 inta_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic seq(input bit three, input bit vld, input int lvl);
        call_mode = three; win_valid = vld; win_level = 3'(lvl);
        repeat (three ? 3 : 2) pulse();
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        vec_base = 5'h15; call_lo = 3'd5; call_hi = 8'h9A; slave_id = 3'd4;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!data_oe && !cas_oe && !isr_set && cas_out == 0, "R1 reset",
            {data_oe, cas_oe, isr_set}, 0);
        in_reset = 0;
        // Master, no cascade
        sp_en_in = 1'b1;
        seq(1, 1, 3);
        seq(0, 1, 5);
        seq(0, 0, 2);       // no winner: level 7
        // Cascaded master
        slave_map = 8'b0000_0100;
        seq(0, 1, 2);
        seq(1, 1, 2);
        seq(1, 1, 6);
        // Slave, match and mismatch
        sp_en_in = 1'b0; cas_in = 3'd4;
        seq(0, 1, 1);
        seq(1, 1, 1);
        cas_in = 3'd3;
        seq(0, 1, 1);
        // Buffered mode, role from configuration
        buf_mode = 1'b1; cfg_master = 1'b1; slave_map = 8'd0;
        seq(1, 1, 0);
        // R10: back to back sequences with no gap
        call_mode = 1'b0; win_valid = 1'b1; win_level = 3'd6;
        repeat (4) pulse();
        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule